// File: doc/BRIEF.md
# Edge-Triggered Tri-State Phase Detector

This block compares the rising edges of a reference clock and a feedback clock (typically a divided oscillator output) and reports which one arrived first. Both inputs are treated as asynchronous digital signals. They are synchronized into a fast system clock domain, and the block acts only on their rising edges. Signal levels and duty cycle play no part.

When the reference edge comes first, the block raises a pump-up pulse. When the feedback edge comes first, it raises a pump-down pulse. The pulse lasts until the matching edge arrives on the other input. The charge-pump style output has three parts: a drive-high, a drive-low, and a high-impedance enable. Outside a pulse the output floats, and inputs that stay in lock produce no activity at all.

A lock monitor counts consecutive reference edges during which no error pulse grew wider than a programmable tolerance. It raises a lock flag once that count reaches a programmable target.

Top module: `edge_phase_detector`

## Requirements
- R1: Each input passes through a two-stage synchronizer and an edge detector. A rising transition made between two system clock edges shows on the outputs after the third following rising edge of `clk`, and not before.
- R2: From idle, a reference rising edge alone asserts `drive_hi_o`. A feedback rising edge alone asserts `drive_lo_o`. The two are never asserted together.
- R3: A pulse ends on the rising edge of the other input. Its length in system cycles equals the separation of the two edges in system cycles.
- R4: Rising edges on both inputs that are detected in the same system cycle while idle produce no pulse.
- R5: `hiz_o` is 1 exactly when neither `drive_hi_o` nor `drive_lo_o` is 1, and 0 throughout any pulse.
- R6: Only rising edges matter. The input high time (duty cycle) and the falling edges do not change pulse direction or length.
- R7: A repeated rising edge on the leading input during an active pulse neither ends nor restarts the pulse. The pulse runs from the first leading edge until the other input's edge.
- R8: `lock_o` rises once `lock_cnt_i` consecutive reference edges have been detected while no active pulse was longer than `tol_i` cycles.
- R9: A pulse that stays active for more than `tol_i` cycles clears `lock_o` on the next clock edge and restarts the edge count. Pulses of at most `tol_i` cycles leave the lock flag alone.
- R10: When `rst_n` is 0 at a rising edge of `clk`, the block returns to idle. The output goes to high impedance, `lock_o` is 0 and the edge count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_in | input | 1 | Reference clock, asynchronous |
| fb_in | input | 1 | Feedback clock, asynchronous |
| tol_i | input | WIDTH_W | Largest pulse length, in cycles, still counted as locked |
| lock_cnt_i | input | LOCK_W | Number of consecutive good reference edges needed for lock |
| drive_hi_o | output | 1 | Source current (reference leads) |
| drive_lo_o | output | 1 | Sink current (feedback leads) |
| hiz_o | output | 1 | Output floats (no pulse) |
| lock_o | output | 1 | Lock indicator |

## Verification
The bench measures pulse lengths for edge separations of one cycle upward in both directions, and for coincident edges. A detector that misjudged latency or pulse ending would report lengths off by one or would leak a pulse at lock. It repeats the same edge timing with short and long high times; a detector that looked at levels would then give different lengths. A second reference edge inside an up pulse is applied, because a design that restarted or flipped the pulse there would lose frequency detection. The lock flag is tested at exactly the target edge count, with pulses at and just above the tolerance, and the bench then checks that a reset in the middle of a pulse drops both the pulse and the lock flag.

// File: rtl/edge_phase_detector_pkg.sv
// Shared types for the edge-triggered phase detector.
package edge_phase_detector_pkg;

    // Detector state: idle (floating), reference leading, feedback leading.
    typedef enum logic [1:0] {
        PD_IDLE = 2'd0,
        PD_UP   = 2'd1,
        PD_DN   = 2'd2
    } pd_state_e;

    // Number of compared inputs (reference, feedback).
    localparam int unsigned PD_NUM_IN = 2;
    localparam int unsigned PD_REF    = 0;
    localparam int unsigned PD_FB     = 1;

endpackage

// File: rtl/pfd_edge_sync.sv
// pfd_edge_sync
// Brings one asynchronous input into the clk domain through STAGES flip-flops
// and flags the cycle in which a rising edge reaches the synchronized output.
// Assumes the input stays high and low for at least one clk period each.
module pfd_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    // chain[STAGES-1] is the synchronized level, chain[STAGES] its last value.
    logic [STAGES:0] chain_q;

    // Shift the input through the synchronizer and the edge history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], async_i};
        end
    end

    // A rising edge is a synchronized 1 that followed a 0.
    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/pfd_state_core.sv
// pfd_state_core
// Three-state edge comparator. A reference edge seen while idle starts an up
// pulse. A feedback edge seen while idle starts a down pulse. An up pulse ends
// only on a feedback edge and a down pulse only on a reference edge. Further
// edges on the leading input leave the pulse running. Simultaneous edges while
// idle cancel out. Also counts the length of the active pulse, saturating.
module pfd_state_core
    import edge_phase_detector_pkg::*;
#(
    parameter int unsigned WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_rise_i,
    input  logic               fb_rise_i,
    output logic               up_o,
    output logic               dn_o,
    output logic               active_o,
    output logic [WIDTH_W-1:0] width_o
);

    localparam logic [WIDTH_W-1:0] WIDTH_MAX = {WIDTH_W{1'b1}};

    pd_state_e          state_q, state_d;
    logic [WIDTH_W-1:0] width_q;

    // Pick the next state from the current state and the two edge flags.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_IDLE: begin
                if (ref_rise_i && !fb_rise_i) begin
                    state_d = PD_UP;
                end else if (fb_rise_i && !ref_rise_i) begin
                    state_d = PD_DN;
                end
            end
            PD_UP: begin
                if (fb_rise_i) begin
                    state_d = PD_IDLE;
                end
            end
            PD_DN: begin
                if (ref_rise_i) begin
                    state_d = PD_IDLE;
                end
            end
            default: state_d = PD_IDLE;
        endcase
    end

    // Hold the state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Count the cycles of the current pulse: 1 in its first cycle, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q <= '0;
        end else if (state_d == PD_IDLE) begin
            width_q <= '0;
        end else if (state_q == PD_IDLE) begin
            width_q <= {{(WIDTH_W-1){1'b0}}, 1'b1};
        end else if (width_q != WIDTH_MAX) begin
            width_q <= width_q + 1'b1;
        end
    end

    assign up_o     = (state_q == PD_UP);
    assign dn_o     = (state_q == PD_DN);
    assign active_o = (state_q != PD_IDLE);
    assign width_o  = width_q;

endmodule

// File: rtl/pfd_lock_monitor.sv
// pfd_lock_monitor
// Counts consecutive reference edges seen while no pulse has grown past the
// tolerance. Sets the lock flag once the count reaches the target. A pulse
// longer than the tolerance clears both the flag and the count at once.
// Assumes tol_i and lock_cnt_i are held steady while lock is being judged.
module pfd_lock_monitor #(
    parameter int unsigned WIDTH_W = 8,
    parameter int unsigned LOCK_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_rise_i,
    input  logic               active_i,
    input  logic [WIDTH_W-1:0] width_i,
    input  logic [WIDTH_W-1:0] tol_i,
    input  logic [LOCK_W-1:0]  lock_cnt_i,
    output logic               over_o,
    output logic               lock_o
);

    localparam logic [LOCK_W-1:0] CNT_MAX = {LOCK_W{1'b1}};

    logic [LOCK_W-1:0] cnt_q;
    logic [LOCK_W-1:0] cnt_inc;
    logic              lock_q;

    // Flag a pulse that has run longer than the tolerance.
    assign over_o  = active_i && (width_i > tol_i);
    // Count of good edges including this one, saturating.
    assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

    // Track consecutive good reference edges and the lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lock_q <= 1'b0;
        end else if (over_o) begin
            cnt_q  <= '0;
            lock_q <= 1'b0;
        end else if (ref_rise_i) begin
            cnt_q  <= cnt_inc;
            if (cnt_inc >= lock_cnt_i) begin
                lock_q <= 1'b1;
            end
        end
    end

    assign lock_o = lock_q;

endmodule

// File: rtl/edge_phase_detector.sv
// edge_phase_detector
// Top of the edge-triggered tri-state phase detector. Synchronizes the
// reference and feedback inputs, compares their rising edges, drives the
// three-part charge-pump output and reports lock. Assumes both inputs are
// slower than clk / 2 so that each level lasts at least one clk period.
module edge_phase_detector
    import edge_phase_detector_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned WIDTH_W     = 8,
    parameter int unsigned LOCK_W      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_in,
    input  logic               fb_in,
    input  logic [WIDTH_W-1:0] tol_i,
    input  logic [LOCK_W-1:0]  lock_cnt_i,
    output logic               drive_hi_o,
    output logic               drive_lo_o,
    output logic               hiz_o,
    output logic               lock_o
);

    logic [PD_NUM_IN-1:0] raw_in;
    logic [PD_NUM_IN-1:0] rise;
    logic                 ref_rise;
    logic                 fb_rise;
    logic                 up;
    logic                 dn;
    logic                 active;
    logic                 over;
    logic [WIDTH_W-1:0]   width;

    assign raw_in[PD_REF] = ref_in;
    assign raw_in[PD_FB]  = fb_in;

    // One synchronizer and edge detector per compared input.
    for (genvar gi = 0; gi < PD_NUM_IN; gi++) begin : g_sync
        pfd_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) sync_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (raw_in[gi]),
            .rise_o  (rise[gi])
        );
    end

    assign ref_rise = rise[PD_REF];
    assign fb_rise  = rise[PD_FB];

    pfd_state_core #(
        .WIDTH_W (WIDTH_W)
    ) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_rise_i (ref_rise),
        .fb_rise_i  (fb_rise),
        .up_o       (up),
        .dn_o       (dn),
        .active_o   (active),
        .width_o    (width)
    );

    pfd_lock_monitor #(
        .WIDTH_W (WIDTH_W),
        .LOCK_W  (LOCK_W)
    ) lock_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_rise_i (ref_rise),
        .active_i   (active),
        .width_i    (width),
        .tol_i      (tol_i),
        .lock_cnt_i (lock_cnt_i),
        .over_o     (over),
        .lock_o     (lock_o)
    );

    // Charge-pump style output: source, sink, or float.
    assign drive_hi_o = up;
    assign drive_lo_o = dn;
    assign hiz_o      = ~(up | dn);

endmodule

// File: rtl/edge_phase_detector_chk.sv
// edge_phase_detector_chk
// Temporal checks on the phase detector, bound to every instance of the top.
// Looks at the detected edge flags, the over-tolerance flag and the outputs.
module edge_phase_detector_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_rise,
    input logic fb_rise,
    input logic over,
    input logic drive_hi,
    input logic drive_lo,
    input logic hiz,
    input logic lock
);

    // R2: source and sink are never driven together.
    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_hi && drive_lo));

    // R2: an up pulse starts only from a lone reference edge.
    a_r2_up_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(drive_hi) && $past(rst_n)) |-> ($past(ref_rise) && !$past(fb_rise)));

    // R3: an up pulse ends only on a feedback edge.
    a_r3_up_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(drive_hi) && $past(rst_n)) |-> $past(fb_rise));

    // R3: a down pulse ends only on a reference edge.
    a_r3_dn_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(drive_lo) && $past(rst_n)) |-> $past(ref_rise));

    // R4: coincident edges while floating keep the output floating.
    a_r4_coincident: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rise && fb_rise && hiz) |=> hiz);

    // R7: without a feedback edge an up pulse carries on.
    a_r7_up_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_hi && !fb_rise) |=> drive_hi);

    // R8: the lock flag rises only on a reference edge.
    a_r8_lock_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lock) && $past(rst_n)) |-> $past(ref_rise));

    // R9: an over-long pulse drops lock on the next edge.
    a_r9_lock_drop: assert property (@(posedge clk) disable iff (!rst_n)
        over |=> !lock);

    // R10: reset leaves the output floating and lock cleared.
    a_r10_reset: assert property (@(posedge clk)
        !rst_n |=> (!drive_hi && !drive_lo && !lock));

endmodule

bind edge_phase_detector edge_phase_detector_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_rise (ref_rise),
    .fb_rise  (fb_rise),
    .over     (over),
    .drive_hi (drive_hi_o),
    .drive_lo (drive_lo_o),
    .hiz      (hiz_o),
    .lock     (lock_o)
);

// File: tb/edge_phase_detector_tb_top.sv
// Directed bench for edge_phase_detector: one task per scenario.
module edge_phase_detector_tb_top;

    localparam int WIDTH_W = 8;
    localparam int LOCK_W  = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ref_in = 1'b0;
    logic               fb_in = 1'b0;
    logic [WIDTH_W-1:0] tol_i = 8'd2;
    logic [LOCK_W-1:0]  lock_cnt_i = 8'd4;
    logic               drive_hi_o;
    logic               drive_lo_o;
    logic               hiz_o;
    logic               lock_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    edge_phase_detector #(
        .SYNC_STAGES (2),
        .WIDTH_W     (WIDTH_W),
        .LOCK_W      (LOCK_W)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_in     (ref_in),
        .fb_in      (fb_in),
        .tol_i      (tol_i),
        .lock_cnt_i (lock_cnt_i),
        .drive_hi_o (drive_hi_o),
        .drive_lo_o (drive_lo_o),
        .hiz_o      (hiz_o),
        .lock_o     (lock_o)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Raise ref at cycle ra and fb at cycle fa, each high for hr cycles.
    // Count up cycles, down cycles and cycles where the outputs disagree.
    task automatic run_pair(input int ra, input int fa, input int hr,
                            output int hi_n, output int lo_n, output int bad_n);
        int last = ((ra > fa) ? ra : fa) + hr + 6;
        hi_n = 0; lo_n = 0; bad_n = 0;
        for (int t = 0; t <= last; t++) begin
            @(negedge clk);
            if (drive_hi_o) hi_n++;
            if (drive_lo_o) lo_n++;
            if ((drive_hi_o && drive_lo_o) || (hiz_o == (drive_hi_o | drive_lo_o))) bad_n++;
            if (t == ra)      ref_in = 1'b1;
            if (t == ra + hr) ref_in = 1'b0;
            if (t == fa)      fb_in  = 1'b1;
            if (t == fa + hr) fb_in  = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_in = 1'b0;
        fb_in = 1'b0;
        wait_cycles(4);
        rst_n = 1'b1;
        wait_cycles(2);
    endtask

    // R10: state right after reset.
    task automatic t_reset_state();
        wait_cycles(4);
        check("R10 hi after reset", drive_hi_o, 0);
        check("R10 lo after reset", drive_lo_o, 0);
        check("R10 hiz after reset", hiz_o, 1);
        check("R10 lock after reset", lock_o, 0);
        rst_n = 1'b1;
        wait_cycles(2);
    endtask

    // R1, R5: latency of a lone reference edge and the float enable.
    task automatic t_latency();
        @(negedge clk);
        ref_in = 1'b1;
        wait_cycles(2);
        check("R1 no up before third edge", drive_hi_o, 0);
        wait_cycles(1);
        check("R1 up after third edge", drive_hi_o, 1);
        check("R5 hiz low during pulse", hiz_o, 0);
        ref_in = 1'b0;
        wait_cycles(4);
        fb_in = 1'b1;
        wait_cycles(5);
        fb_in = 1'b0;
        check("R3 up ended by fb edge", drive_hi_o, 0);
        check("R5 hiz back high", hiz_o, 1);
        wait_cycles(3);
    endtask

    // R2, R3, R4, R5: direction and length for several separations.
    task automatic t_direction();
        int hi_n, lo_n, bad_n;
        run_pair(0, 5, 3, hi_n, lo_n, bad_n);
        check("R3 up length 5", hi_n, 5);
        check("R2 no down when ref leads", lo_n, 0);
        check("R5 hiz consistent", bad_n, 0);
        run_pair(6, 0, 3, hi_n, lo_n, bad_n);
        check("R3 down length 6", lo_n, 6);
        check("R2 no up when fb leads", hi_n, 0);
        check("R5 hiz consistent fb lead", bad_n, 0);
        run_pair(0, 1, 2, hi_n, lo_n, bad_n);
        check("R3 up length 1", hi_n, 1);
        run_pair(1, 0, 2, hi_n, lo_n, bad_n);
        check("R3 down length 1", lo_n, 1);
        run_pair(0, 0, 3, hi_n, lo_n, bad_n);
        check("R4 coincident no up", hi_n, 0);
        check("R4 coincident no down", lo_n, 0);
    endtask

    // R6: same edge timing with short and long high times.
    task automatic t_duty();
        int hi_n, lo_n, bad_n;
        run_pair(0, 4, 2, hi_n, lo_n, bad_n);
        check("R6 short high time up length", hi_n, 4);
        run_pair(0, 4, 11, hi_n, lo_n, bad_n);
        check("R6 long high time up length", hi_n, 4);
        check("R6 long high time no down", lo_n, 0);
    endtask

    // R7: second reference edge inside an up pulse.
    task automatic t_repeat_edge();
        int hi_n = 0;
        int lo_n = 0;
        for (int t = 0; t <= 22; t++) begin
            @(negedge clk);
            if (drive_hi_o) hi_n++;
            if (drive_lo_o) lo_n++;
            ref_in = (t >= 0 && t < 2) || (t >= 6 && t < 8);
            fb_in  = (t >= 12 && t < 14);
        end
        check("R7 up spans both ref edges", hi_n, 12);
        check("R7 no down pulse", lo_n, 0);
    endtask

    // R8, R9: lock acquisition, tolerance and loss.
    task automatic t_lock();
        int hi_n, lo_n, bad_n;
        tol_i = 8'd2;
        lock_cnt_i = 8'd4;
        do_reset();
        for (int k = 0; k < 3; k++) run_pair(0, 0, 3, hi_n, lo_n, bad_n);
        check("R8 no lock after 3 edges", lock_o, 0);
        run_pair(0, 0, 3, hi_n, lo_n, bad_n);
        check("R8 lock after 4 edges", lock_o, 1);
        run_pair(0, 2, 3, hi_n, lo_n, bad_n);
        check("R9 up at tolerance keeps lock", lock_o, 1);
        run_pair(2, 0, 3, hi_n, lo_n, bad_n);
        check("R9 down at tolerance keeps lock", lock_o, 1);
        run_pair(0, 3, 3, hi_n, lo_n, bad_n);
        check("R9 wide pulse drops lock", lock_o, 0);
        for (int k = 0; k < 3; k++) run_pair(0, 0, 3, hi_n, lo_n, bad_n);
        check("R9 count restarted after loss", lock_o, 0);
        run_pair(0, 0, 3, hi_n, lo_n, bad_n);
        check("R8 relock after 4 more edges", lock_o, 1);
    endtask

    // R10: reset in the middle of a pulse while locked.
    task automatic t_reset_mid();
        tol_i = 8'd50;
        @(negedge clk);
        ref_in = 1'b1;
        wait_cycles(5);
        check("R10 pulse active before reset", drive_hi_o, 1);
        check("R10 lock held before reset", lock_o, 1);
        rst_n = 1'b0;
        ref_in = 1'b0;
        wait_cycles(1);
        check("R10 up cleared by reset", drive_hi_o, 0);
        check("R10 hiz set by reset", hiz_o, 1);
        check("R10 lock cleared by reset", lock_o, 0);
        wait_cycles(2);
        rst_n = 1'b1;
        wait_cycles(5);
        check("R10 idle after release", drive_hi_o | drive_lo_o, 0);
    endtask

    initial begin
        t_reset_state();
        t_latency();
        t_direction();
        t_duty();
        t_repeat_edge();
        t_lock();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule